// File: doc/BRIEF.md
# Burst-Capable Strobed Register Bus Slave

This block is the slave end of an asynchronous, strobe-driven host bus with separate address and data strobes. It sits between an 8-bit bidirectional data bus and a small internal register array. The host selects the block with an active-low chip select. The host places an address and raises the address strobe, which sets the starting location. The host then runs one or more data strobe cycles. For each cycle, the read/write line picks the direction and an active-low acknowledge tells the host when the cycle may be ended.

The first data strobe cycle after an address strobe accesses the latched address. Each further data strobe cycle without a new address strobe accesses the next location, so a block of consecutive registers can be read or written with one address phase. All strobes are brought into the internal clock domain through a two-stage synchronizer before any edge is acted on.

Top module: `mbus_burst_slave`

## Requirements
- R1: After reset the acknowledge output is high, the data bus is released, and every register location reads 0x00.
- R2: A low-to-high transition of the address strobe, while chip select is low, latches the 7-bit address bus as the start address. The next data strobe cycle accesses exactly that location.
- R3: A data strobe cycle with the read/write line high (read) returns the contents of the accessed location on the data bus. The block drives the bus only while that read cycle is acknowledged.
- R4: A data strobe cycle with the read/write line low (write) stores the data bus byte into the accessed location when the data strobe returns high. A write cycle is acknowledged in the same way as a read.
- R5: When the data strobe is first held low before a rising clock edge, the acknowledge goes low after the fourth rising clock edge. This is two synchronizer stages plus a fixed delay of ACK_DLY=2 clocks after the falling edge is detected.
- R6: Once the data strobe returns high, the acknowledge returns high and the data bus is released within three clocks.
- R7: Each data strobe cycle after the first, with no new address strobe in between, accesses the location one above the previous one.
- R8: The burst address wraps from 0x7F to 0x00.
- R9: With chip select high, a data strobe cycle is not acknowledged, does not drive the bus, and does not write any location.
- R10: A new address strobe in the middle of a burst restarts the sequence at the newly latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Address strobe, active low; address latched on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| rnw | input | 1 | Cycle direction: 1 = read, 0 = write |
| ds_n | input | 1 | Data strobe, active low |
| addr_i | input | 7 | Register address |
| data_io | inout | 8 | Bidirectional data bus |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
On every cycle, the assertions check the following:
- a detected strobe fall with chip select present always starts an access;
- a raised strobe or a removed select always returns the controller to idle;
- a deselected block stays idle;
- a burst step advances the access address by exactly one, modulo 128;
- bus drive and register writes never happen together.

Only the directed scenarios can show the following:
- the values actually stored and returned;
- the exact acknowledge latency seen at the pins;
- bus release;
- wrap-around from 0x7F;
- a burst restart after a new address strobe;
- the absence of any write while deselected.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int MB_ADDR_W  = 7;
    localparam int MB_DATA_W  = 8;
    localparam int MB_ACK_DLY = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } bus_st_e;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] out_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = in_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign out_o = stg_q[STAGES-1];
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) mem_d[wr_addr_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W  = MB_ADDR_W,
    parameter int DATA_W  = MB_DATA_W,
    parameter int ACK_DLY = MB_ACK_DLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s_i,
    input  logic              cs_s_i,
    input  logic              ds_s_i,
    input  logic              rnw_s_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              dtack_n_o
);
    localparam int CNT_W = (ACK_DLY > 2) ? $clog2(ACK_DLY) : 1;

    typedef struct packed {
        bus_st_e           state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] cur_addr;
        logic              new_pend;
        logic              is_wr;
        logic [DATA_W-1:0] rdata;
        logic              oe;
        logic              as_p;
        logic              ds_p;
    } ctrl_t;

    ctrl_t q, d;
    logic  as_rise, ds_fall, ds_rise, release_req;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb begin
        as_rise     = !q.as_p && as_s_i;
        ds_fall     = q.ds_p && !ds_s_i;
        ds_rise     = !q.ds_p && ds_s_i;
        release_req = ds_s_i || cs_s_i;
        nxt_addr    = q.new_pend ? q.cur_addr : q.cur_addr + ADDR_W'(1);

        d       = q;
        d.as_p  = as_s_i;
        d.ds_p  = ds_s_i;
        wr_en_o = 1'b0;

        if (as_rise && !cs_s_i) begin
            d.cur_addr = addr_i;
            d.new_pend = 1'b1;
        end

        unique case (q.state)
            ST_IDLE: begin
                if (ds_fall && !cs_s_i) begin
                    d.state    = ST_WAIT;
                    d.cnt      = CNT_W'(ACK_DLY - 2);
                    d.cur_addr = nxt_addr;
                    d.new_pend = 1'b0;
                    d.is_wr    = !rnw_s_i;
                    d.rdata    = rd_data_i;
                end
            end
            ST_WAIT: begin
                if (release_req) begin
                    d.state = ST_IDLE;
                end else if (q.cnt == '0) begin
                    d.state = ST_ACK;
                    d.oe    = !q.is_wr;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_ACK: begin
                if (release_req) begin
                    d.state = ST_IDLE;
                    d.oe    = 1'b0;
                    wr_en_o = ds_rise && !cs_s_i && q.is_wr;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.new_pend <= 1'b1;
            q.as_p     <= 1'b1;
            q.ds_p     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o = nxt_addr;
    assign wr_addr_o = q.cur_addr;
    assign oe_o      = q.oe;
    assign rdata_o   = q.rdata;
    assign dtack_n_o = !(q.state == ST_ACK);

    AST_START_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && q.ds_p && !ds_s_i && !cs_s_i) |=> (q.state == ST_WAIT)); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE && (ds_s_i || cs_s_i)) |=> (q.state == ST_IDLE && !q.oe)); // R6
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s_i |=> (q.state == ST_IDLE)); // R9
    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && q.ds_p && !ds_s_i && !cs_s_i && !q.new_pend)
        |=> (q.cur_addr == ADDR_W'($past(q.cur_addr) + ADDR_W'(1)))); // R7
    AST_DRIVE_XOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.oe, wr_en_o})); // R3
    AST_OE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.state == ST_ACK && !q.is_wr)); // R3
endmodule

// File: rtl/mbus_burst_slave.sv
module mbus_burst_slave
    import mbus_pkg::*;
#(
    parameter int ADDR_W   = MB_ADDR_W,
    parameter int DATA_W   = MB_DATA_W,
    parameter int ACK_DLY  = MB_ACK_DLY,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              cs_n,
    input  logic              rnw,
    input  logic              ds_n,
    input  logic [ADDR_W-1:0] addr_i,
    inout  wire  [DATA_W-1:0] data_io,
    output logic              dtack_n
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0]  sync_out;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, rdata;
    logic              wr_en, oe;

    mbus_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STG), .RST_VAL('1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({as_n, cs_n, ds_n, rnw}),
        .out_o (sync_out)
    );

    mbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_DLY(ACK_DLY)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_s_i    (sync_out[3]),
        .cs_s_i    (sync_out[2]),
        .ds_s_i    (sync_out[1]),
        .rnw_s_i   (sync_out[0]),
        .addr_i    (addr_i),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .oe_o      (oe),
        .rdata_o   (rdata),
        .dtack_n_o (dtack_n)
    );

    mbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (data_io),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    assign data_io = oe ? rdata : 'z;

    AST_ACK_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> !sync_out[2]); // R9
endmodule

// File: tb/test_mbus_burst_slave.sv
module test_mbus_burst_slave;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       as_n = 1, cs_n = 1, rnw = 1, ds_n = 1;
    logic [6:0] addr = '0;
    logic       tb_oe = 0;
    logic [7:0] tb_d = '0;
    wire  [7:0] dbus;
    logic       dtack_n;
    int         n_chk = 0, n_fail = 0;

    assign dbus = tb_oe ? tb_d : 'z;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_burst_slave i_mbus_burst_slave (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n), .rnw(rnw),
        .ds_n(ds_n), .addr_i(addr), .data_io(dbus), .dtack_n(dtack_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic latch_addr(input logic [6:0] a);
        @(negedge clk); cs_n = 0; as_n = 0; addr = a;
        repeat (3) @(negedge clk);
        as_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_cycle(input bit wr, input logic [7:0] wv,
                             output logic [7:0] rv, output int lat);
        @(negedge clk); rnw = !wr;
        if (wr) begin tb_oe = 1; tb_d = wv; end
        @(negedge clk); ds_n = 0; lat = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); lat++;
            if (dtack_n == 0) break;
        end
        rv = dbus;
        ds_n = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (dtack_n == 1) break;
        end
        repeat (3) @(negedge clk);
        tb_oe = 0; rnw = 1;
    endtask

    task automatic check_released(input string req);
        @(negedge clk); tb_oe = 1; tb_d = 8'h00;
        @(negedge clk);
        chk(dtack_n == 1'b1, req, dtack_n, 1);
        chk(dbus == 8'h00, req, dbus, 8'h00);
        tb_oe = 0;
    endtask

    task automatic t_reset();
        logic [7:0] rv; int lat;
        check_released("R1");
        latch_addr(7'h05);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'h00, "R1 reset contents", rv, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] rv; int lat;
        latch_addr(7'h10);
        bus_cycle(1, 8'hA5, rv, lat);
        chk(lat == 4, "R4 write acknowledged R5", lat, 4);
        latch_addr(7'h10);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'hA5, "R2 R3 readback", rv, 8'hA5);
        chk(lat == 4, "R5 read ack latency", lat, 4);
        check_released("R6");
    endtask

    task automatic t_burst();
        logic [7:0] rv; int lat;
        latch_addr(7'h20);
        for (int i = 0; i < 4; i++) bus_cycle(1, 8'h30 + 8'(i), rv, lat);
        latch_addr(7'h20);
        for (int i = 0; i < 4; i++) begin
            bus_cycle(0, 8'h00, rv, lat);
            chk(rv == 8'h30 + 8'(i), "R7 burst read", rv, 8'h30 + i);
        end
    endtask

    task automatic t_wrap();
        logic [7:0] rv; int lat;
        latch_addr(7'h7E);
        bus_cycle(1, 8'h7E, rv, lat);
        bus_cycle(1, 8'h7F, rv, lat);
        bus_cycle(1, 8'hC0, rv, lat);
        latch_addr(7'h7F);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'h7F, "R8 last location", rv, 8'h7F);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'hC0, "R8 wrap to 0x00", rv, 8'hC0);
    endtask

    task automatic t_deselect();
        logic [7:0] rv; int lat;
        bit acked = 0;
        latch_addr(7'h40);
        @(negedge clk); cs_n = 1; rnw = 0; tb_oe = 1; tb_d = 8'h5A;
        @(negedge clk); ds_n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (dtack_n == 0) acked = 1;
        end
        ds_n = 1;
        repeat (5) @(negedge clk);
        tb_oe = 0; rnw = 1;
        chk(!acked, "R9 no ack while deselected", acked, 0);
        check_released("R9");
        latch_addr(7'h40);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'h00, "R9 no write while deselected", rv, 8'h00);
    endtask

    task automatic t_restart();
        logic [7:0] rv; int lat;
        latch_addr(7'h10);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'hA5, "R10 first access", rv, 8'hA5);
        latch_addr(7'h22);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'h32, "R10 restart address", rv, 8'h32);
        bus_cycle(0, 8'h00, rv, lat);
        chk(rv == 8'h33, "R10 R7 continue after restart", rv, 8'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_wrap();
        t_deselect();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule